// File: doc/BRIEF.md
# Page Private/Shared Classifier

This block decides, for every physical page, whether the page belongs to a single core or is shared by several cores. It is consulted only when a core takes a TLB miss. The miss request carries the requesting core's id and the page number. The block looks up a direct-indexed classification table and updates the entry if needed. It then answers with a one-bit class, which the core stores in its new TLB entry.

The first core to miss on an unclassified page becomes its owner, and the page is marked private. A miss on that page from any other core turns the page shared, and a shared page stays shared. When a page moves from private to shared, the block sends an invalidate to the former owner. The owner must drop its TLB entry and evict the page's blocks from its local cache slice. The requester's answer is held back until the owner acknowledges the invalidate. No new miss is accepted while the invalidate is outstanding.

Top module: `page_class_tracker`

## Requirements
- R1: A synchronous reset marks every table entry unclassified. After reset, `req_ready` is 1 and `rsp_valid` and `inv_valid` are 0.
- R2: A miss accepted (`req_valid` and `req_ready`) on an unclassified page records the requester as owner and marks the page private. In the next cycle `rsp_valid` is 1 for one cycle with `rsp_shared`=0, and `rsp_core`/`rsp_page` echo the request.
- R3: A miss from the recorded owner of a private page leaves the entry unchanged. The next-cycle response has `rsp_shared`=0.
- R4: A miss from a different core on a private page raises `inv_valid` in the next cycle, with `inv_core` set to the owner and `inv_page` to the page. The invalidate and its fields stay unchanged until `inv_ack` is seen high.
- R5: While `inv_valid` is 1, `req_ready` is 0. Requests presented in that time are ignored: they change no entry and get no response.
- R6: In the cycle after `inv_ack` is seen high while `inv_valid` is 1, `inv_valid` falls. In that same cycle the response to the core that caused the transition appears, with `rsp_shared`=1.
- R7: Shared is final. A miss on a shared page, even from the former owner, is answered with `rsp_shared`=1 in the next cycle and raises no invalidate.
- R8: Each page has its own entry, indexed directly by the page number. Activity on one page never changes the class or owner of another page.
- R9: `inv_ack` has no effect while no invalidate is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | TLB-miss classification request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_core | input | 4 | Requesting core id |
| req_page | input | 6 | Page number (table index) |
| rsp_valid | output | 1 | Class answer valid (one cycle) |
| rsp_core | output | 4 | Core the answer is for |
| rsp_page | output | 6 | Page the answer is for |
| rsp_shared | output | 1 | 0 = private, 1 = shared |
| inv_valid | output | 1 | Invalidate request to a former owner |
| inv_core | output | 4 | Core that must drop the page |
| inv_page | output | 6 | Page to shoot down and evict |
| inv_ack | input | 1 | Owner has completed the invalidate |

## Verification
The bench targets the private-to-shared transition. This includes the request that arrives during the invalidate stall: a design that accepted it would emit an extra response or corrupt a second page. It also probes a former owner returning after the transition: a design that let shared fall back to private would answer 0 there and hand out a stale private class. A stray acknowledge with nothing outstanding would, in a faulty design, produce a phantom shared response. Aliasing between neighbouring pages would show up as a wrong owner or a wrong class on an unrelated page, which the randomized phase exposes by confining traffic to a few pages.

// File: rtl/pct_pkg.sv
package pct_pkg;
    // Stored class encoding (2 bits). An entry whose valid bit is 0 is unclassified.
    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_PRIV = 2'b01,
        CLS_SHRD = 2'b10,
        CLS_INSN = 2'b11
    } pg_class_e;
endpackage

// File: rtl/pct_table.sv
module pct_table
    import pct_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CORE_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output pg_class_e         rd_cls,
    output logic [CORE_W-1:0] rd_owner,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  pg_class_e         wr_cls,
    input  logic [CORE_W-1:0] wr_owner
);
    typedef struct packed {
        logic              valid;
        pg_class_e         cls;
        logic [CORE_W-1:0] owner;
    } entry_t;

    entry_t tbl_q [DEPTH];
    entry_t tbl_d [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = '{valid: 1'b1, cls: wr_cls, owner: wr_owner};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_valid = tbl_q[rd_idx].valid;
    assign rd_cls   = tbl_q[rd_idx].cls;
    assign rd_owner = tbl_q[rd_idx].owner;

    // A shared entry is never rewritten to another class
    assert_shared_final_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tbl_q[wr_idx].valid && tbl_q[wr_idx].cls == CLS_SHRD) |-> (wr_cls == CLS_SHRD));
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl
    import pct_pkg::*;
#(
    parameter int CORE_W = 4,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [IDX_W-1:0]  req_page,
    input  logic              tbl_valid,
    input  pg_class_e         tbl_cls,
    input  logic [CORE_W-1:0] tbl_owner,
    output logic              wr_en,
    output pg_class_e         wr_cls,
    output logic [CORE_W-1:0] wr_owner,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic [IDX_W-1:0]  rsp_page,
    output logic              rsp_shared,
    output logic              inv_valid,
    output logic [CORE_W-1:0] inv_core,
    output logic [IDX_W-1:0]  inv_page,
    input  logic              inv_ack
);
    typedef struct packed {
        logic              busy;
        logic              rsp_valid;
        logic              rsp_shared;
        logic [CORE_W-1:0] rsp_core;
        logic [IDX_W-1:0]  rsp_page;
        logic [CORE_W-1:0] inv_core;
        logic [CORE_W-1:0] pend_core;
        logic [IDX_W-1:0]  pend_page;
    } state_t;

    state_t s_q, s_d;
    logic   accept;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        wr_en         = 1'b0;
        wr_cls        = CLS_PRIV;
        wr_owner      = req_core;
        accept        = req_valid && !s_q.busy;
        if (s_q.busy) begin
            if (inv_ack) begin
                s_d.busy       = 1'b0;
                s_d.rsp_valid  = 1'b1;
                s_d.rsp_shared = 1'b1;
                s_d.rsp_core   = s_q.pend_core;
                s_d.rsp_page   = s_q.pend_page;
            end
        end else if (accept) begin
            s_d.rsp_core = req_core;
            s_d.rsp_page = req_page;
            if (!tbl_valid) begin
                wr_en          = 1'b1;
                s_d.rsp_valid  = 1'b1;
                s_d.rsp_shared = 1'b0;
            end else if (tbl_cls != CLS_PRIV) begin
                s_d.rsp_valid  = 1'b1;
                s_d.rsp_shared = 1'b1;
            end else if (tbl_owner == req_core) begin
                s_d.rsp_valid  = 1'b1;
                s_d.rsp_shared = 1'b0;
            end else begin
                wr_en         = 1'b1;
                wr_cls        = CLS_SHRD;
                wr_owner      = tbl_owner;
                s_d.busy      = 1'b1;
                s_d.inv_core  = tbl_owner;
                s_d.pend_core = req_core;
                s_d.pend_page = req_page;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign req_ready  = !s_q.busy;
    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_core   = s_q.rsp_core;
    assign rsp_page   = s_q.rsp_page;
    assign rsp_shared = s_q.rsp_shared;
    assign inv_valid  = s_q.busy;
    assign inv_core   = s_q.inv_core;
    assign inv_page   = s_q.pend_page;

    assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !req_ready);
    assert_inv_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !inv_ack) |=> (inv_valid && $stable(inv_core) && $stable(inv_page)));
    assert_ack_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_ack) |=> (rsp_valid && rsp_shared && !inv_valid));
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid ^ inv_valid));
    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (!inv_valid && !req_valid) |=> !rsp_valid);
endmodule

// File: rtl/page_class_tracker.sv
module page_class_tracker
    import pct_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int NUM_PAGES = 64,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [PAGE_W-1:0] req_page,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic [PAGE_W-1:0] rsp_page,
    output logic              rsp_shared,
    output logic              inv_valid,
    output logic [CORE_W-1:0] inv_core,
    output logic [PAGE_W-1:0] inv_page,
    input  logic              inv_ack
);
    logic              tbl_valid;
    pg_class_e         tbl_cls;
    logic [CORE_W-1:0] tbl_owner;
    logic              wr_en;
    pg_class_e         wr_cls;
    logic [CORE_W-1:0] wr_owner;

    pct_table #(.DEPTH(NUM_PAGES), .CORE_W(CORE_W)) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(req_page), .rd_valid(tbl_valid), .rd_cls(tbl_cls), .rd_owner(tbl_owner),
        .wr_en(wr_en), .wr_idx(req_page), .wr_cls(wr_cls), .wr_owner(wr_owner)
    );

    pct_ctrl #(.CORE_W(CORE_W), .IDX_W(PAGE_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core), .req_page(req_page),
        .tbl_valid(tbl_valid), .tbl_cls(tbl_cls), .tbl_owner(tbl_owner),
        .wr_en(wr_en), .wr_cls(wr_cls), .wr_owner(wr_owner),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_page(rsp_page), .rsp_shared(rsp_shared),
        .inv_valid(inv_valid), .inv_core(inv_core), .inv_page(inv_page), .inv_ack(inv_ack)
    );
endmodule

// File: tb/page_class_tracker_test.sv
module page_class_tracker_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_core = '0;
    logic [5:0] req_page = '0;
    logic       rsp_valid;
    logic [3:0] rsp_core;
    logic [5:0] rsp_page;
    logic       rsp_shared;
    logic       inv_valid;
    logic [3:0] inv_core;
    logic [5:0] inv_page;
    logic       inv_ack = 1'b0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    page_class_tracker uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core), .req_page(req_page),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_page(rsp_page), .rsp_shared(rsp_shared),
        .inv_valid(inv_valid), .inv_core(inv_core), .inv_page(inv_page), .inv_ack(inv_ack)
    );

    // Behavioural reference model
    bit    m_cls_valid [64];
    bit    m_cls_shared [64];
    int    m_owner [64];
    bit    m_busy;
    int    m_inv_core, m_pend_core, m_pend_page;
    bit    e_rv, e_sh;
    int    e_core, e_page;
    string e_tag;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 64; i++) begin
            m_cls_valid[i] = 0; m_cls_shared[i] = 0; m_owner[i] = 0;
        end
        m_busy = 0; e_rv = 0;
    endtask

    task automatic model_step(input bit r, input bit v, input int c, input int p, input bit a);
        e_rv = 0;
        if (r) begin
            model_clear();
        end else if (m_busy) begin
            if (a) begin
                m_busy = 0; e_rv = 1; e_sh = 1;
                e_core = m_pend_core; e_page = m_pend_page; e_tag = "R6";
            end
        end else if (v) begin
            e_core = c; e_page = p;
            if (!m_cls_valid[p]) begin
                m_cls_valid[p] = 1; m_owner[p] = c;
                e_rv = 1; e_sh = 0; e_tag = "R2";
            end else if (m_cls_shared[p]) begin
                e_rv = 1; e_sh = 1; e_tag = "R7";
            end else if (m_owner[p] == c) begin
                e_rv = 1; e_sh = 0; e_tag = "R3";
            end else begin
                m_cls_shared[p] = 1; m_busy = 1;
                m_inv_core = m_owner[p]; m_pend_core = c; m_pend_page = p;
            end
        end else if (a) begin
            e_tag = "R9";
        end
    endtask

    task automatic compare();
        chk("R5 ready", int'(req_ready), int'(!m_busy));
        chk("R4 inv_valid", int'(inv_valid), int'(m_busy));
        if (m_busy) begin
            chk("R4 inv_core", int'(inv_core), m_inv_core);
            chk("R4 inv_page", int'(inv_page), m_pend_page);
        end
        chk({e_tag, " rsp_valid"}, int'(rsp_valid), int'(e_rv));
        if (e_rv) begin
            chk({e_tag, " rsp_core"}, int'(rsp_core), e_core);
            chk({e_tag, " rsp_page"}, int'(rsp_page), e_page);
            chk({e_tag, " rsp_shared"}, int'(rsp_shared), int'(e_sh));
        end
    endtask

    task automatic step(input bit r, input bit v, input int c, input int p, input bit a);
        rst = r; req_valid = v; req_core = c[3:0]; req_page = p[5:0]; inv_ack = a;
        model_step(r, v, c, p, a);
        @(negedge clk);
        compare();
    endtask

    initial begin
        e_tag = "R2";
        model_clear();
        @(negedge clk);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // R1: clean state after reset
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 inv_valid", int'(inv_valid), 0);
        step(0, 1, 3, 5, 0);   // R2 first touch -> private
        step(0, 0, 0, 0, 1);   // R9 stray ack, no effect
        step(0, 1, 3, 5, 0);   // R3 owner again
        step(0, 1, 3, 9, 0);   // R8 another page by same core
        step(0, 1, 7, 5, 0);   // R4 other core -> invalidate core 3
        step(0, 1, 1, 9, 0);   // R5 ignored while stalled
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);   // R6 ack -> shared response to core 7
        step(0, 1, 3, 5, 0);   // R7 former owner sees shared
        step(0, 1, 3, 9, 0);   // R8 page 9 still private to core 3
        step(0, 1, 1, 10, 0);  // R8 neighbour page untouched
        step(1, 0, 0, 0, 0);   // reset mid-run
        step(0, 1, 7, 5, 0);   // R1 page 5 unclassified again -> private
        // Randomized phase on a few pages to force collisions
        for (int n = 0; n < 4000; n++) begin
            step(0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 7)), 1'($urandom_range(0, 2) == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule